// File: doc/BRIEF.md
# Virtual-Wire System Event Edge Capture

This block watches two 32-bit vectors of system-event wire levels that a link front end has already decoded from the host. It turns selected transitions on those wires into latched status bits. Each wire has its own trigger type, selected by a 3-bit code. The three bits of that code sit in three separate type registers, at the wire's bit position. A per-group enable register decides which wires may latch.

A top-level summary word collects three things: a pending flag for each group and a flag for a hardware reset seen on the link. The summary word is masked by its own enable register and drives one level-sensitive interrupt line. Software reaches every register through a simple single-cycle read/write port with combinational read data.

Register map (word addresses on `addr_i`):
- Group g base = 8*g.
- +0: sampled level (read only).
- +1: T0. +2: T1. +3: T2.
- +4: enable.
- +5: status (write one to clear).
- Other group offsets read zero.
- Address 16: summary status (write one to clear).
- Address 17: summary enable.

Top module: `vwc_capture`

## Requirements
- R1: After reset every register reads zero and `irq_o` is low.
- R2: A bit whose code {T2,T1,T0} is 3'b100 latches status on both a rising and a falling level change. The status appears at the clock edge that first samples the new level, and a steady level latches nothing.
- R3: Code 3'b001 latches only on a rising level change.
- R4: Code 3'b010 latches only on a falling level change.
- R5: Every other code latches on each clock edge at which the level is high.
- R6: A status bit never latches while its enable bit is zero, whatever its code and level.
- R7: Writing the group status register clears exactly the bits written as one and leaves the other bits unchanged.
- R8: If a clearing write and a new trigger hit the same status bit in the same cycle, the bit stays set.
- R9: Summary bit 8 (group 0) and summary bit 22 (group 1) latch in any cycle in which that group latches at least one status bit. They are write one to clear.
- R10: Summary bit 31 latches on a rising edge of `link_rst_i` only; a held high level does not set it again after it is cleared.
- R11: `irq_o` is high exactly while some summary status bit is set together with its summary enable bit.
- R12: The type and enable registers read back what was written, and the level register returns the level sampled at the last clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| grp0_lvl_i | input | 32 | Group 0 wire levels |
| grp1_lvl_i | input | 32 | Group 1 wire levels |
| link_rst_i | input | 1 | Hardware reset indication from the link |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | Write when high, read when low |
| addr_i | input | 5 | Word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational from `addr_i` |
| irq_o | output | 1 | Level interrupt |

## Verification
A vector walk covers every trigger code against every pair of old and new levels. A wrongly decoded code would latch on the opposite edge, on a steady level, or not at all. A clearing write is made to collide with a fresh edge; a design that lets the clear win would lose that event. A held-high link reset is cleared and checked again, which catches a design that treats the reset as a level and re-arms it forever. The interrupt is checked with the enable mask set and with it unset, so a mask that is ignored or inverted shows up as a wrong `irq_o`.

// File: rtl/vwc_pkg.sv
package vwc_pkg;
  localparam int unsigned DATA_W   = 32;
  localparam int unsigned ADDR_W   = 5;
  localparam int unsigned NUM_GRP  = 2;
  localparam int unsigned GRP_SPAN = 8;
  localparam int unsigned HWRST_BIT = 31;

  typedef enum logic [2:0] {
    OFS_LVL = 3'd0,
    OFS_T0  = 3'd1,
    OFS_T1  = 3'd2,
    OFS_T2  = 3'd3,
    OFS_EN  = 3'd4,
    OFS_STS = 3'd5
  } grp_ofs_e;

  typedef enum logic [1:0] {
    TRG_LEVEL = 2'd0,
    TRG_RISE  = 2'd1,
    TRG_FALL  = 2'd2,
    TRG_BOTH  = 2'd3
  } trig_e;

  function automatic trig_e trig_decode(input logic t2, input logic t1, input logic t0);
    case ({t2, t1, t0})
      3'b100:  return TRG_BOTH;
      3'b001:  return TRG_RISE;
      3'b010:  return TRG_FALL;
      default: return TRG_LEVEL;
    endcase
  endfunction

  function automatic int unsigned sum_bit(input int unsigned grp);
    return (grp == 0) ? 8 : 22;
  endfunction
endpackage

// File: rtl/vwc_edge_detect.sv
module vwc_edge_detect
  import vwc_pkg::*;
#(
  parameter int unsigned W = DATA_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] lvl_i,
  input  logic [W-1:0] t0_i,
  input  logic [W-1:0] t1_i,
  input  logic [W-1:0] t2_i,
  input  logic [W-1:0] en_i,
  output logic [W-1:0] lvl_q_o,
  output logic [W-1:0] hit_o
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= lvl_i;
  end

  assign lvl_q_o = prev_q;

  for (genvar i = 0; i < W; i++) begin : g_bit
    trig_e trig;
    logic  rise, fall;
    assign trig = trig_decode(t2_i[i], t1_i[i], t0_i[i]);
    assign rise = lvl_i[i] & ~prev_q[i];
    assign fall = ~lvl_i[i] & prev_q[i];
    always_comb begin
      case (trig)
        TRG_BOTH: hit_o[i] = en_i[i] & (rise | fall);
        TRG_RISE: hit_o[i] = en_i[i] & rise;
        TRG_FALL: hit_o[i] = en_i[i] & fall;
        default:  hit_o[i] = en_i[i] & lvl_i[i];
      endcase
    end
  end
endmodule

// File: rtl/vwc_event_group.sv
module vwc_event_group
  import vwc_pkg::*;
#(
  parameter int unsigned W = DATA_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] lvl_i,
  input  logic         wr_i,
  input  logic [2:0]   ofs_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] rdata_o,
  output logic         set_any_o
);
  logic [W-1:0] t0_q, t1_q, t2_q, en_q, sts_q, lvl_q, hit;
  logic         sts_wr;

  vwc_edge_detect #(.W(W)) u_det (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .lvl_i   (lvl_i),
    .t0_i    (t0_q),
    .t1_i    (t1_q),
    .t2_i    (t2_q),
    .en_i    (en_q),
    .lvl_q_o (lvl_q),
    .hit_o   (hit)
  );

  assign sts_wr = wr_i && (ofs_i == OFS_STS);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      t0_q  <= '0;
      t1_q  <= '0;
      t2_q  <= '0;
      en_q  <= '0;
      sts_q <= '0;
    end else begin
      if (wr_i && ofs_i == OFS_T0) t0_q <= wdata_i;
      if (wr_i && ofs_i == OFS_T1) t1_q <= wdata_i;
      if (wr_i && ofs_i == OFS_T2) t2_q <= wdata_i;
      if (wr_i && ofs_i == OFS_EN) en_q <= wdata_i;
      // set has priority over clear
      sts_q <= (sts_q & ~(sts_wr ? wdata_i : '0)) | hit;
    end
  end

  always_comb begin
    case (ofs_i)
      OFS_LVL: rdata_o = lvl_q;
      OFS_T0:  rdata_o = t0_q;
      OFS_T1:  rdata_o = t1_q;
      OFS_T2:  rdata_o = t2_q;
      OFS_EN:  rdata_o = en_q;
      OFS_STS: rdata_o = sts_q;
      default: rdata_o = '0;
    endcase
  end

  assign set_any_o = |hit;

  // R6
  en_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((sts_q & ~$past(sts_q) & ~$past(en_q)) == '0));
  // R7
  w1c_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sts_wr && hit == '0) |=> ((sts_q & $past(wdata_i)) == '0));
  // R8
  set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit != '0) |=> ((sts_q & $past(hit)) == $past(hit)));
endmodule

// File: rtl/vwc_summary.sv
module vwc_summary
  import vwc_pkg::*;
#(
  parameter int unsigned W  = DATA_W,
  parameter int unsigned NG = NUM_GRP
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [NG-1:0] grp_set_i,
  input  logic          hw_rst_i,
  input  logic          wr_i,
  input  logic          sel_en_i,
  input  logic [W-1:0]  wdata_i,
  output logic [W-1:0]  rdata_o,
  output logic          irq_o
);
  logic [W-1:0] sts_q, en_q, set_vec;
  logic         hw_prev_q, hw_edge;

  assign hw_edge = hw_rst_i & ~hw_prev_q;

  always_comb begin
    set_vec = '0;
    for (int unsigned g = 0; g < NG; g++) begin
      if (grp_set_i[g]) set_vec[sum_bit(g)] = 1'b1;
    end
    if (hw_edge) set_vec[HWRST_BIT] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sts_q     <= '0;
      en_q      <= '0;
      hw_prev_q <= 1'b0;
    end else begin
      hw_prev_q <= hw_rst_i;
      if (wr_i && sel_en_i) en_q <= wdata_i;
      sts_q <= (sts_q & ~((wr_i && !sel_en_i) ? wdata_i : '0)) | set_vec;
    end
  end

  assign rdata_o = sel_en_i ? en_q : sts_q;
  assign irq_o   = |(sts_q & en_q);

  for (genvar g = 0; g < NG; g++) begin : g_sum_chk
    localparam int unsigned B = sum_bit(g);
    // R9
    grp_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(sts_q[B]) |-> $past(grp_set_i[g]));
  end

  // R10
  hw_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sts_q[HWRST_BIT]) |-> $past(hw_rst_i && !hw_prev_q));
endmodule

// File: rtl/vwc_capture.sv
module vwc_capture
  import vwc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] grp0_lvl_i,
  input  logic [DATA_W-1:0] grp1_lvl_i,
  input  logic              link_rst_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  logic [NUM_GRP-1:0][DATA_W-1:0] lvl, grp_rdata;
  logic [NUM_GRP-1:0]             grp_set;
  logic [DATA_W-1:0]              sum_rdata;
  logic                           wr, top_sel;

  assign lvl[0]  = grp0_lvl_i;
  assign lvl[1]  = grp1_lvl_i;
  assign wr      = req_i & we_i;
  assign top_sel = addr_i[4];

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    logic grp_wr;
    assign grp_wr = wr && !top_sel && (addr_i[3] == 1'(g));
    vwc_event_group #(.W(DATA_W)) u_grp (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .lvl_i     (lvl[g]),
      .wr_i      (grp_wr),
      .ofs_i     (addr_i[2:0]),
      .wdata_i   (wdata_i),
      .rdata_o   (grp_rdata[g]),
      .set_any_o (grp_set[g])
    );
  end

  vwc_summary #(.W(DATA_W), .NG(NUM_GRP)) u_sum (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .grp_set_i (grp_set),
    .hw_rst_i  (link_rst_i),
    .wr_i      (wr && top_sel),
    .sel_en_i  (addr_i[0]),
    .wdata_i   (wdata_i),
    .rdata_o   (sum_rdata),
    .irq_o     (irq_o)
  );

  always_comb begin
    if (top_sel) rdata_o = (addr_i[3:1] == 3'd0) ? sum_rdata : '0;
    else         rdata_o = grp_rdata[addr_i[3]];
  end
endmodule

// File: tb/sim_vwc_capture.sv
module sim_vwc_capture;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] g0 = '0, g1 = '0, wdata = '0, rdata;
  logic        lrst = 1'b0, req = 1'b0, we = 1'b0, irq;
  logic [4:0]  addr = '0;
  int          n_chk = 0, n_fail = 0;

  localparam logic [4:0] A_LVL = 5'd0, A_T0 = 5'd1, A_T1 = 5'd2, A_T2 = 5'd3,
                         A_EN = 5'd4, A_STS = 5'd5, G1 = 5'd8,
                         A_TSTS = 5'd16, A_TEN = 5'd17;

  // {T2 T1 T0, enable, old level, new level, expected status}
  // codes: 100 both edges, 001 rise, 010 fall, any other = level high
  localparam logic [6:0] VEC [0:14] = '{
    7'b100_1_0_1_1, 7'b100_1_1_0_1, 7'b100_1_0_0_0, 7'b100_1_1_1_0,
    7'b001_1_0_1_1, 7'b001_1_1_0_0, 7'b001_1_1_1_0,
    7'b010_1_1_0_1, 7'b010_1_0_1_0,
    7'b000_1_1_1_1, 7'b000_1_0_0_0, 7'b111_1_0_1_1, 7'b011_1_1_0_0,
    7'b100_0_0_1_0, 7'b000_0_1_1_0
  };

  always #10 clk = ~clk;

  vwc_capture u0 (
    .clk_i(clk), .rst_ni(rst_n), .grp0_lvl_i(g0), .grp1_lvl_i(g1),
    .link_rst_i(lrst), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  initial begin
    #(20ns * 100000);
    n_fail++;
    $display("FAIL watchdog act=hung exp=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    string tag;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tick();

    // R1 reset state
    foreach (VEC[i]) begin end
    for (int a = 0; a < 18; a++) begin
      rd(5'(a), d);
      chk("R1 reg", d, 32'h0);
    end
    chk("R1 irq", {31'h0, irq}, 32'h0);

    // R12 readback and sampled level
    wr(A_T0, 32'hA5A5_5A5A); rd(A_T0, d); chk("R12 T0", d, 32'hA5A5_5A5A);
    wr(A_T1, 32'h1234_5678); rd(A_T1, d); chk("R12 T1", d, 32'h1234_5678);
    wr(G1 + A_EN, 32'h0F0F_0000); rd(G1 + A_EN, d); chk("R12 EN", d, 32'h0F0F_0000);
    wr(G1 + A_EN, 32'h0);
    g1 = 32'hDEAD_BEEF; tick();
    rd(G1 + A_LVL, d); chk("R12 LVL", d, 32'hDEAD_BEEF);
    g1 = '0; tick();

    // R2..R6 vector walk on group 0 bit 3
    foreach (VEC[i]) begin
      logic [2:0] code;
      code = VEC[i][6:4];
      if (!VEC[i][3])           tag = "R6";
      else if (code == 3'b100)  tag = "R2";
      else if (code == 3'b001)  tag = "R3";
      else if (code == 3'b010)  tag = "R4";
      else                      tag = "R5";
      wr(A_EN, 32'h0);
      wr(A_T0, {28'h0, code[0], 3'b0});
      wr(A_T1, {28'h0, code[1], 3'b0});
      wr(A_T2, {28'h0, code[2], 3'b0});
      g0 = {28'h0, VEC[i][2], 3'b0};
      repeat (2) tick();
      wr(A_STS, 32'hFFFF_FFFF);
      wr(A_EN, {28'h0, VEC[i][3], 3'b0});
      g0 = {28'h0, VEC[i][1], 3'b0};
      tick();
      rd(A_STS, d);
      chk($sformatf("%s vec%0d", tag, i), d, {28'h0, VEC[i][0], 3'b0});
    end

    // R2 multi-bit dual edge, R7 partial clear
    wr(A_EN, 32'h0); g0 = '0; tick();
    wr(A_T0, 32'h0); wr(A_T1, 32'h0); wr(A_T2, 32'hF);
    wr(A_EN, 32'hF); wr(A_STS, 32'hFFFF_FFFF);
    g0 = 32'hF; tick();
    rd(A_STS, d); chk("R2 multi", d, 32'hF);
    wr(A_STS, 32'h5);
    rd(A_STS, d); chk("R7 w1c", d, 32'hA);

    // R8 clear collides with new edge on bit 0; bit 1 has no edge
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = A_STS; wdata = 32'h3; g0 = 32'hE;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
    rd(A_STS, d); chk("R8 set wins", d, 32'h9);

    // R9 group flags in summary
    wr(A_TSTS, 32'hFFFF_FFFF);
    rd(A_TSTS, d); chk("R9 cleared", d, 32'h0);
    wr(G1 + A_T2, 32'h20); wr(G1 + A_EN, 32'h20);
    g1 = 32'h20; tick();
    rd(A_TSTS, d); chk("R9 grp1", d, 32'h0040_0000);
    g0 = 32'hC; tick();
    rd(A_TSTS, d); chk("R9 both", d, 32'h0040_0100);
    wr(A_TSTS, 32'h100);
    rd(A_TSTS, d); chk("R9 w1c", d, 32'h0040_0000);

    // R10 link reset edge
    lrst = 1'b1; tick();
    rd(A_TSTS, d); chk("R10 edge", d, 32'h8040_0000);
    wr(A_TSTS, 32'h8000_0000); tick();
    rd(A_TSTS, d); chk("R10 held", d, 32'h0040_0000);
    lrst = 1'b0; tick(); lrst = 1'b1; tick();
    rd(A_TSTS, d); chk("R10 again", d, 32'h8040_0000);
    lrst = 1'b0;

    // R11 interrupt masking
    tick();
    chk("R11 masked", {31'h0, irq}, 32'h0);
    wr(A_TEN, 32'h0040_0000);
    chk("R11 on", {31'h0, irq}, 32'h1);
    wr(A_TEN, 32'h100);
    chk("R11 other mask", {31'h0, irq}, 32'h0);
    wr(A_TEN, 32'h8000_0000);
    chk("R11 hw", {31'h0, irq}, 32'h1);
    wr(A_TSTS, 32'h8000_0000);
    chk("R11 cleared", {31'h0, irq}, 32'h0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule